// File: doc/BRIEF.md
# Seven-Level Overlapping-Carrier PWM Modulator

This block turns a signed reference sample into one of seven output levels for a single-phase inverter. It holds one up/down triangle counter. From that counter it derives six triangular carriers, all with the same period and the same peak-to-peak span. Each carrier is lifted half a span above the carrier below it, so their bands overlap. On every sample strobe the reference is compared with all six carriers. The number of carriers lying below the reference, minus three, becomes the output level. A polarity flag follows the sign of that level.

A two-bit arrangement select picks how the carriers are phased. In the in-phase arrangement every carrier rises and falls together. In the split arrangement the upper three carriers run in opposite phase to the lower three. In the alternating arrangement every second carrier is inverted. An inverted carrier uses the counter value reflected about the half period, so every carrier turns at the same strobe.

The arrangement and the half period are taken only where one carrier period ends and the next begins. A carrier cycle is therefore never split between two settings. The reference is produced elsewhere, and the gate drive decodes the level elsewhere.

Top module: `copwm_modulator`

## Requirements
- R1: While reset is held, and on the first clock after it, `level_out` is 0 and `pos_out` is 0. The counter starts at 0 and rises. The active settings are the in-phase arrangement and a half period of HALF_DEF until the first period boundary.
- R2: The counter moves one step per strobe, from 0 up to the active half period H and back down to 0. A full period takes 2·H strobes. The counter does not move on cycles without a strobe.
- R3: For counter value c, carrier k (k = 0..5) equals p + k·floor(H/2). Here p is c for a normal carrier and H − c for an inverted one. The reference is shifted up by floor((H + 5·floor(H/2))/2) before the comparison. The level is the count of carriers strictly below the shifted reference, minus 3. It is given in 3-bit two's complement.
- R4: `mode_sel` = 0 (and the spare code 3) selects the in-phase arrangement, with no carrier inverted.
- R5: `mode_sel` = 1 selects the split arrangement: carriers 3, 4 and 5 are inverted, and carriers 0, 1 and 2 are not.
- R6: `mode_sel` = 2 selects the alternating arrangement: carriers 1, 3 and 5 are inverted.
- R7: `mode_sel` and `half_per` are captured only on the strobe that takes the counter from 1 down to 0. That captured setting governs the carrier period that starts at that point.
- R8: A `half_per` value below 2 is taken as 2.
- R9: `pos_out` goes to 1 when the new level is above 0 and to 0 when it is below 0. It keeps its previous value when the level is 0.
- R10: `level_out` and `pos_out` change only on the clock edge where `smp_en` is high. They are valid straight after that edge.
- R11: A reference above every carrier gives +3. A reference at or below every carrier gives −3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_en | input | 1 | Sample strobe; advances the counter and updates the level |
| ref_in | input | REF_W | Signed reference sample, zero at the carrier stack centre |
| mode_sel | input | 2 | Carrier phase arrangement: 0 in phase, 1 split, 2 alternating |
| half_per | input | CNT_W | Half carrier period in strobes |
| level_out | output | 3 | Signed output level, −3 to +3 |
| pos_out | output | 1 | Polarity of the most recent non-zero level |

## Verification
Each result is due on the first clock edge where `smp_en` is high. The level, the polarity and the counter all take their new values at that edge. The bench raises the strobe for exactly one cycle and samples at the following falling edge. For every strobe it predicts the level from its own model of the counter position, the active half period and the active arrangement.

Settings applied at a boundary take effect on the strobe after the one that returns the counter to 0. The bench's model switches the settings only at that point. Tests that change `mode_sel` in the middle of a period therefore show the old arrangement up to the boundary. Cycles without a strobe are each checked to leave the outputs unchanged, and later levels confirm that the counter did not move.

// File: rtl/copwm_pkg.sv
package copwm_pkg;

  localparam int NCAR  = 6;
  localparam int LVL_W = 3;

  typedef enum logic [1:0] {
    MODE_INPHASE = 2'd0,
    MODE_SPLIT   = 2'd1,
    MODE_ALT     = 2'd2,
    MODE_SPARE   = 2'd3
  } cmode_e;

  // Which carriers run in inverted phase for a given arrangement.
  function automatic logic [NCAR-1:0] phase_mask(cmode_e m);
    logic [NCAR-1:0] msk;
    for (int k = 0; k < NCAR; k++) begin
      case (m)
        MODE_SPLIT: msk[k] = (k >= NCAR / 2);
        MODE_ALT:   msk[k] = (k % 2 == 1);
        default:    msk[k] = 1'b0;
      endcase
    end
    return msk;
  endfunction

  // Carriers below the reference, shifted to a level centred on zero.
  function automatic logic signed [LVL_W-1:0] count_to_level(logic [LVL_W-1:0] n);
    logic signed [LVL_W:0] t;
    if (n > LVL_W'(NCAR)) t = (LVL_W + 1)'(NCAR / 2);
    else                  t = $signed({1'b0, n}) - (LVL_W + 1)'(NCAR / 2);
    return t[LVL_W-1:0];
  endfunction

endpackage

// File: rtl/copwm_tri_counter.sv
module copwm_tri_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic [CNT_W-1:0] half,
  output logic [CNT_W-1:0] cnt,
  output logic             rising,
  output logic             wrap
);

  logic [CNT_W:0] cnt_inc;
  assign cnt_inc = {1'b0, cnt} + (CNT_W + 1)'(1);

  // Strobe that lands the counter on zero: a carrier period ends here.
  assign wrap = step && !rising && (cnt <= CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      rising <= 1'b1;
    end else if (step) begin
      if (rising) begin
        if (cnt_inc >= {1'b0, half}) begin
          cnt    <= half;
          rising <= 1'b0;
        end else begin
          cnt <= cnt_inc[CNT_W-1:0];
        end
      end else begin
        if (cnt <= CNT_W'(1)) begin
          cnt    <= '0;
          rising <= 1'b1;
        end else begin
          cnt <= cnt - CNT_W'(1);
        end
      end
    end
  end

endmodule

// File: rtl/copwm_carrier_bank.sv
module copwm_carrier_bank
  import copwm_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int REF_W = 10,
  parameter int EXT_W = 12
) (
  input  logic [CNT_W-1:0]        cnt,
  input  logic [CNT_W-1:0]        half,
  input  logic [NCAR-1:0]         inv_mask,
  input  logic signed [REF_W-1:0] ref_in,
  output logic [NCAR-1:0]         above
);

  function automatic logic signed [EXT_W-1:0] carrier_value(
    int unsigned k, logic [CNT_W-1:0] c, logic [CNT_W-1:0] h, logic inv);
    logic [EXT_W-1:0] ph;
    logic [EXT_W-1:0] lift;
    ph   = inv ? EXT_W'(h - c) : EXT_W'(c);
    lift = EXT_W'(h >> 1) * EXT_W'(k);
    return $signed(ph + lift);
  endfunction

  function automatic logic signed [EXT_W-1:0] stack_centre(logic [CNT_W-1:0] h);
    logic [EXT_W-1:0] span;
    span = EXT_W'(h) + EXT_W'(NCAR - 1) * EXT_W'(h >> 1);
    return $signed(span >> 1);
  endfunction

  logic signed [EXT_W-1:0] ref_shift;
  assign ref_shift = $signed({{(EXT_W - REF_W){ref_in[REF_W-1]}}, ref_in}) + stack_centre(half);

  for (genvar k = 0; k < NCAR; k++) begin : g_car
    logic signed [EXT_W-1:0] car;
    assign car      = carrier_value(k, cnt, half, inv_mask[k]);
    assign above[k] = ref_shift > car;
  end

endmodule

// File: rtl/copwm_level_encoder.sv
module copwm_level_encoder
  import copwm_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    step,
  input  logic [NCAR-1:0]         above,
  output logic signed [LVL_W-1:0] level,
  output logic                    pos
);

  logic [LVL_W-1:0]        n_above;
  logic signed [LVL_W-1:0] level_nx;

  assign n_above  = LVL_W'($countones(above));
  assign level_nx = count_to_level(n_above);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      level <= '0;
      pos   <= 1'b0;
    end else if (step) begin
      level <= level_nx;
      if (level_nx > 0)      pos <= 1'b1;
      else if (level_nx < 0) pos <= 1'b0;
    end
  end

endmodule

// File: rtl/copwm_modulator.sv
module copwm_modulator
  import copwm_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int REF_W    = 10,
  parameter int HALF_DEF = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    smp_en,
  input  logic signed [REF_W-1:0] ref_in,
  input  logic [1:0]              mode_sel,
  input  logic [CNT_W-1:0]        half_per,
  output logic signed [2:0]       level_out,
  output logic                    pos_out
);

  localparam int EXT_W = ((REF_W > CNT_W + 3) ? REF_W : CNT_W + 3) + 1;

  logic [CNT_W-1:0] cnt;
  logic             rising;
  logic             wrap;
  logic [CNT_W-1:0] half_act;
  cmode_e           mode_act;
  logic [CNT_W-1:0] half_req;
  logic [NCAR-1:0]  inv_mask;
  logic [NCAR-1:0]  above;

  assign half_req = (half_per < CNT_W'(2)) ? CNT_W'(2) : half_per;

  // Settings switch only where one carrier period hands over to the next.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_act <= MODE_INPHASE;
      half_act <= CNT_W'(HALF_DEF);
    end else if (wrap) begin
      mode_act <= cmode_e'(mode_sel);
      half_act <= half_req;
    end
  end

  assign inv_mask = phase_mask(mode_act);

  copwm_tri_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .step   (smp_en),
    .half   (half_act),
    .cnt    (cnt),
    .rising (rising),
    .wrap   (wrap)
  );

  copwm_carrier_bank #(.CNT_W(CNT_W), .REF_W(REF_W), .EXT_W(EXT_W)) u_bank (
    .cnt      (cnt),
    .half     (half_act),
    .inv_mask (inv_mask),
    .ref_in   (ref_in),
    .above    (above)
  );

  copwm_level_encoder u_enc (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (smp_en),
    .above (above),
    .level (level_out),
    .pos   (pos_out)
  );

endmodule

// File: rtl/copwm_modulator_chk.sv
module copwm_modulator_chk #(
  parameter int CNT_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              smp_en,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  half_act,
  input logic [1:0]        mode_act,
  input logic              wrap,
  input logic [5:0]        above,
  input logic signed [2:0] level_out,
  input logic              pos_out
);

  // R10
  level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_en |=> $stable(level_out) && $stable(pos_out));

  // R2
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_en |=> $stable(cnt));

  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= half_act);

  // R7
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(mode_act) && $stable(half_act));

  // R9
  pol_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (level_out > 0) |-> pos_out);

  // R9
  pol_neg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (level_out < 0) |-> !pos_out);

  // R4
  therm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_act == 2'd0) |-> ((above & (above + 6'd1)) == 6'd0));

endmodule

bind copwm_modulator copwm_modulator_chk #(.CNT_W(CNT_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .smp_en    (smp_en),
  .cnt       (cnt),
  .half_act  (half_act),
  .mode_act  (mode_act),
  .wrap      (wrap),
  .above     (above),
  .level_out (level_out),
  .pos_out   (pos_out)
);

// File: tb/copwm_modulator_tb.sv
`timescale 1ns/1ps
module copwm_modulator_tb_top;

  localparam int CNT_W    = 8;
  localparam int REF_W    = 10;
  localparam int HALF_DEF = 8;

  logic                    clk = 1'b0;
  logic                    rst_n;
  logic                    smp_en;
  logic signed [REF_W-1:0] ref_in;
  logic [1:0]              mode_sel;
  logic [CNT_W-1:0]        half_per;
  logic signed [2:0]       level_out;
  logic                    pos_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  // bench model of the counter position and active settings
  int m_pos, m_h, m_mode, m_pol;

  always #10 clk = ~clk;

  copwm_modulator #(.CNT_W(CNT_W), .REF_W(REF_W), .HALF_DEF(HALF_DEF)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_en    (smp_en),
    .ref_in    (ref_in),
    .mode_sel  (mode_sel),
    .half_per  (half_per),
    .level_out (level_out),
    .pos_out   (pos_out)
  );

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int model_level(int r, int c, int h, int md);
    int hv = h / 2;
    int sh = r + (h + 5 * hv) / 2;
    int n  = 0;
    for (int k = 0; k < 6; k++) begin
      bit inv = (md == 1 && k >= 3) || (md == 2 && (k % 2) == 1);
      int car = (inv ? h - c : c) + k * hv;
      if (sh > car) n++;
    end
    return n - 3;
  endfunction

  function automatic int model_cnt();
    return (m_pos <= m_h) ? m_pos : 2 * m_h - m_pos;
  endfunction

  task automatic apply_reset();
    rst_n = 1'b0; smp_en = 1'b0; ref_in = '0; mode_sel = 2'd0; half_per = CNT_W'(HALF_DEF);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    m_pos = 0; m_h = HALF_DEF; m_mode = 0; m_pol = 0;
  endtask

  task automatic do_step(int r, int md, int hp, string req);
    int e;
    @(negedge clk);
    ref_in = REF_W'(r); mode_sel = 2'(md); half_per = CNT_W'(hp); smp_en = 1'b1;
    e = model_level(r, model_cnt(), m_h, m_mode);
    @(negedge clk);
    smp_en = 1'b0;
    check(level_out == 3'(e), req, int'(level_out), e);
    if (e > 0) m_pol = 1; else if (e < 0) m_pol = 0;
    check(pos_out == m_pol[0], {req, " R9 pol"}, int'(pos_out), m_pol);
    m_pos++;
    if (m_pos == 2 * m_h) begin
      m_pos  = 0;
      m_h    = (hp < 2) ? 2 : hp;
      m_mode = md;
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; smp_en = 1'b0;
    @(negedge clk);
    check(level_out == 3'sd0, "R1 level in reset", int'(level_out), 0);
    check(pos_out == 1'b0, "R1 pol in reset", int'(pos_out), 0);
    apply_reset();
    @(negedge clk);
    check(level_out == 3'sd0, "R1 level after reset", int'(level_out), 0);
    check(pos_out == 1'b0, "R1 pol after reset", int'(pos_out), 0);
  endtask

  task automatic t_inphase();
    apply_reset();
    // R1: default settings; R3/R4 carrier geometry over two periods
    for (int i = 0; i < 32; i++) do_step(((i * 7) % 31) - 15, 0, HALF_DEF, "R4 R3 in-phase");
    do_step(25, 0, HALF_DEF, "R11 top");
    do_step(-25, 0, HALF_DEF, "R11 bottom");
    // hand value: H=8, c=2, ref 0 -> shifted 14 above 2,6,10 -> 0
    check(model_level(0, 2, 8, 0) == 0, "R3 hand model", model_level(0, 2, 8, 0), 0);
  endtask

  task automatic t_split();
    apply_reset();
    for (int i = 0; i < 48; i++) do_step(((i * 5) % 27) - 13, 1, HALF_DEF, "R5 split");
  endtask

  task automatic t_alt();
    apply_reset();
    for (int i = 0; i < 48; i++) do_step(((i * 11) % 29) - 14, 2, HALF_DEF, "R6 alternating");
    for (int i = 0; i < 32; i++) do_step(((i * 3) % 25) - 12, 3, HALF_DEF, "R4 spare code");
  endtask

  task automatic t_defer();
    apply_reset();
    for (int i = 0; i < 3; i++) do_step(i - 1, 0, HALF_DEF, "R7 pre");
    // request another arrangement mid-period: old one must persist to the boundary
    for (int i = 0; i < 40; i++) do_step(((i * 9) % 23) - 11, 1, HALF_DEF, "R7 deferred mode");
  endtask

  task automatic t_hold();
    int lv, pv;
    apply_reset();
    for (int i = 0; i < 5; i++) do_step(6 - i, 0, HALF_DEF, "R10 pre");
    lv = int'(level_out); pv = int'(pos_out);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      ref_in = REF_W'(20 - 9 * i); mode_sel = 2'd2;
      check(int'(level_out) == lv, "R10 no strobe level", int'(level_out), lv);
      check(int'(pos_out) == pv, "R10 no strobe pol", int'(pos_out), pv);
    end
    for (int i = 0; i < 12; i++) do_step(((i * 4) % 17) - 8, 0, HALF_DEF, "R2 counter held");
  endtask

  task automatic t_period();
    apply_reset();
    for (int i = 0; i < 16; i++) do_step(i - 8, 0, 12, "R7 period request");
    for (int i = 0; i < 24; i++) do_step(((i * 7) % 41) - 20, 0, 12, "R2 half 12");
    // minimum clamp: 0 behaves as 2
    while (m_pos != 0 || m_h != 2) do_step(0, 0, 0, "R8 to clamp");
    for (int i = 0; i < 12; i++) do_step((i % 9) - 4, 2, 0, "R8 half clamp");
  endtask

  task automatic t_polarity();
    apply_reset();
    do_step(25, 0, HALF_DEF, "R9 high");
    // level 0 when shifted ref = c + 9 (three carriers below)
    for (int i = 0; i < 3; i++) begin
      do_step(model_cnt() - 5, 0, HALF_DEF, "R9 zero holds 1");
      check(pos_out == 1'b1, "R9 held high", int'(pos_out), 1);
    end
    do_step(-25, 0, HALF_DEF, "R9 low");
    for (int i = 0; i < 3; i++) begin
      do_step(model_cnt() - 5, 0, HALF_DEF, "R9 zero holds 0");
      check(pos_out == 1'b0, "R9 held low", int'(pos_out), 0);
    end
  endtask

  initial begin
    t_reset();
    t_inphase();
    t_split();
    t_alt();
    t_defer();
    t_hold();
    t_period();
    t_polarity();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

endmodule